// File: doc/BRIEF.md
# Steerable 32-Source Interrupt Controller

The block gathers 32 interrupt inputs and condenses them into two request lines and one wake line. Software gives each source one of six trigger behaviours through a 3-bit code. Each code bit lives in its own register, and each register has a write-ones-to-set offset and a write-ones-to-clear offset. Further per-source registers hold the enable mask, the wake enable, the choice of request line and the choice of input (external pin or test register bit).

Pins pass through a two-flop synchroniser. Edge events are kept in rising and falling capture registers until software clears them by writing ones. Level sources follow the synchronised input directly. A source is pending when its trigger condition holds and its mask bit is set. Each request line has a readable bitmap of its pending sources. Line 0 is the one serviced first, so it is meant for the urgent sources. Two offsets mean one register on read and a different one on write.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, the three config registers, mask, assignment, wake enable, both capture registers and the test register read 0. Source select reads all ones. req0, req1 and wake are low.
- R2: A write to a set offset (0x40 cfg0, 0x48 cfg1, 0x50 cfg2, 0x58 source select, 0x60 assignment, 0x68 wake, 0x70 mask) sets only the bits written as 1. A write to the matching clear offset (0x44, 0x4C, 0x54, 0x5C, 0x64, 0x6C, 0x74) clears only the bits written as 1. The set offsets read back their register.
- R3: A read of 0x54 returns the pending bitmap of req0, and a write there clears cfg2 bits. A read of 0x5C returns the pending bitmap of req1, and a write there clears source-select bits. Writing ones to 0x78 or 0x7C clears those rising or falling capture bits, and reads of those offsets return the captures. 0x80 is a plain read/write test register.
- R4: With mode {cfg2,cfg1,cfg0}=001, a rising edge sets the rising capture bit and raises the request. The bit stays set after the input returns low and is cleared only by a write to 0x78. A falling edge is not captured.
- R5: With mode 010, a falling edge sets the falling capture bit and raises the request. A rising edge is not captured.
- R6: With mode 011, either edge is captured in its own register and raises the request.
- R7: With mode 101, the source is pending while its synchronised input is 1, and nothing is captured.
- R8: With mode 110, the source is pending while its synchronised input is 0.
- R9: Modes 000, 100 and 111 never make a source pending and never capture.
- R10: The pending bit of a source is its trigger condition AND its mask bit. An assignment bit of 1 routes the source to req0, and 0 routes it to req1. Each request line is the OR of its pending bitmap.
- R11: wake is the OR over sources of (trigger condition AND wake enable), whatever the mask bits are.
- R12: A source-select bit of 1 takes the synchronised pin as the source. A bit of 0 takes the matching test-register bit instead and ignores the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, acts at the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_in | input | 32 | Raw asynchronous interrupt inputs |
| req0 | output | 1 | Request line 0 (higher priority) |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake indication |

## Verification
A register write takes effect at the clock edge where reg_wr is sampled, and reads are combinational, so the bench reads back at the next falling edge. A pin change made at a falling edge reaches level-mode requests after two rising edges and edge-mode captures after three. The bench waits four full cycles after each pin change before it samples. A test-register bit used as a source has no synchroniser and acts from the edge that writes it. All sampling happens half a cycle away from the active edge.

// File: rtl/irq_steer_pkg.sv
// Package: shared offsets and trigger codes for the steerable interrupt controller.
// Assumes byte offsets of 8 bits and 32-bit registers.
package irq_steer_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CFG0_SET = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CFG0_CLR = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_CFG1_SET = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_CFG1_CLR = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_CFG2_SET = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_CFG2_CLR = 8'h54; // read: pending of line 0
    localparam logic [ADDR_W-1:0] OFS_SSEL_SET = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_SSEL_CLR = 8'h5C; // read: pending of line 1
    localparam logic [ADDR_W-1:0] OFS_ASGN_SET = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_ASGN_CLR = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_WAKE_SET = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_WAKE_CLR = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_RCAP     = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_FCAP     = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_TEST     = 8'h80;

    typedef enum logic [2:0] {
        TRIG_OFF   = 3'b000,
        TRIG_RISE  = 3'b001,
        TRIG_FALL  = 3'b010,
        TRIG_BOTH  = 3'b011,
        TRIG_LVL_H = 3'b101,
        TRIG_LVL_L = 3'b110
    } trig_e;
endpackage

// File: rtl/irq_sync2.sv
// Module: two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is needed across bits.
module irq_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the raw inputs into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/irq_src_cell.sv
// Module: trigger logic of one interrupt source. It detects edges on the
// selected, already synchronous signal, holds the edge captures and derives the
// unmasked trigger condition from the 3-bit mode.
// Assumes sig is synchronous to clk. Codes 100 and 111 act as disabled.
module irq_src_cell
    import irq_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [2:0] mode,
    input  logic       rise_clr,
    input  logic       fall_clr,
    output logic       rise_cap,
    output logic       fall_cap,
    output logic       pend_raw
);
    logic sig_d;
    logic rise_ev;
    logic fall_ev;
    logic edge_mode;

    // Previous value of the signal, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig;
    end

    assign rise_ev   = sig & ~sig_d;
    assign fall_ev   = ~sig & sig_d;
    assign edge_mode = ~mode[2];

    // Edge captures: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cap <= 1'b0;
            fall_cap <= 1'b0;
        end else begin
            if (edge_mode && mode[0] && rise_ev) rise_cap <= 1'b1;
            else if (rise_clr)                   rise_cap <= 1'b0;
            if (edge_mode && mode[1] && fall_ev) fall_cap <= 1'b1;
            else if (fall_clr)                   fall_cap <= 1'b0;
        end
    end

    // Unmasked trigger condition for the current mode.
    always_comb begin
        case (mode)
            TRIG_RISE, TRIG_FALL, TRIG_BOTH: pend_raw = rise_cap | fall_cap;
            TRIG_LVL_H:                      pend_raw = sig;
            TRIG_LVL_L:                      pend_raw = ~sig;
            default:                         pend_raw = 1'b0;
        endcase
    end

    // A capture, once set, stays until cleared by software.
    assert_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_cap && !rise_clr) |=> rise_cap);
    assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_cap && !fall_clr) |=> fall_cap);
    // Level and undefined modes never create a capture.
    assert_level_nocap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[2] && !rise_cap && !fall_cap) |=> (!rise_cap && !fall_cap));
endmodule

// File: rtl/irq_regbank.sv
// Module: per-source set/clear register bank. It holds the three trigger-code
// bits, source select, assignment, wake enable, mask and the test register.
// Assumes single-cycle writes; a set offset and a clear offset never coincide.
module irq_regbank
    import irq_steer_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   cfg0,
    output logic [NSRC-1:0]   cfg1,
    output logic [NSRC-1:0]   cfg2,
    output logic [NSRC-1:0]   ssel,
    output logic [NSRC-1:0]   asgn,
    output logic [NSRC-1:0]   wake_en,
    output logic [NSRC-1:0]   mask,
    output logic [NSRC-1:0]   test_bits,
    output logic [NSRC-1:0]   rcap_clr,
    output logic [NSRC-1:0]   fcap_clr
);
    // Register update: ones set or clear the matching bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0      <= '0;
            cfg1      <= '0;
            cfg2      <= '0;
            ssel      <= '1;
            asgn      <= '0;
            wake_en   <= '0;
            mask      <= '0;
            test_bits <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CFG0_SET: cfg0      <= cfg0 | reg_wdata;
                OFS_CFG0_CLR: cfg0      <= cfg0 & ~reg_wdata;
                OFS_CFG1_SET: cfg1      <= cfg1 | reg_wdata;
                OFS_CFG1_CLR: cfg1      <= cfg1 & ~reg_wdata;
                OFS_CFG2_SET: cfg2      <= cfg2 | reg_wdata;
                OFS_CFG2_CLR: cfg2      <= cfg2 & ~reg_wdata;
                OFS_SSEL_SET: ssel      <= ssel | reg_wdata;
                OFS_SSEL_CLR: ssel      <= ssel & ~reg_wdata;
                OFS_ASGN_SET: asgn      <= asgn | reg_wdata;
                OFS_ASGN_CLR: asgn      <= asgn & ~reg_wdata;
                OFS_WAKE_SET: wake_en   <= wake_en | reg_wdata;
                OFS_WAKE_CLR: wake_en   <= wake_en & ~reg_wdata;
                OFS_MASK_SET: mask      <= mask | reg_wdata;
                OFS_MASK_CLR: mask      <= mask & ~reg_wdata;
                OFS_TEST:     test_bits <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Capture-clear strobes for the source cells.
    always_comb begin
        rcap_clr = (reg_wr && reg_addr == OFS_RCAP) ? reg_wdata : '0;
        fcap_clr = (reg_wr && reg_addr == OFS_FCAP) ? reg_wdata : '0;
    end

    // Set and clear writes touch exactly the bits written as one.
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASK_SET) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));
    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASK_CLR) |=> ((mask & ~$past(reg_wdata)) == ($past(mask) & ~$past(reg_wdata))));
    // The offset shared with the pending read of line 1 clears source select.
    assert_ssel_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_SSEL_CLR) |=> ((ssel & $past(reg_wdata)) == '0));
endmodule

// File: rtl/irq_steer_ctrl.sv
// Module: top of the steerable interrupt controller. It synchronises the pins,
// picks pin or test bit per source, runs one trigger cell per source, masks and
// steers the pending sources onto two request lines, and drives wake and the
// read mux.
// Assumes NSRC equals the register width of 32.
module irq_steer_ctrl
    import irq_steer_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    input  logic [NSRC-1:0]   src_in,
    output logic              req0,
    output logic              req1,
    output logic              wake
);
    logic [NSRC-1:0] cfg0, cfg1, cfg2, ssel, asgn, wake_en, mask, test_bits;
    logic [NSRC-1:0] rcap_clr, fcap_clr, rcap, fcap;
    logic [NSRC-1:0] pin_sync, sel_sig, pend_raw, pend, pend0, pend1;

    irq_sync2 #(.WIDTH(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (src_in),
        .d_sync  (pin_sync)
    );

    irq_regbank #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cfg0      (cfg0),
        .cfg1      (cfg1),
        .cfg2      (cfg2),
        .ssel      (ssel),
        .asgn      (asgn),
        .wake_en   (wake_en),
        .mask      (mask),
        .test_bits (test_bits),
        .rcap_clr  (rcap_clr),
        .fcap_clr  (fcap_clr)
    );

    // Source choice: synchronised pin or test register bit.
    assign sel_sig = (pin_sync & ssel) | (test_bits & ~ssel);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig      (sel_sig[i]),
            .mode     ({cfg2[i], cfg1[i], cfg0[i]}),
            .rise_clr (rcap_clr[i]),
            .fall_clr (fcap_clr[i]),
            .rise_cap (rcap[i]),
            .fall_cap (fcap[i]),
            .pend_raw (pend_raw[i])
        );
    end

    // Masking and steering onto the two request lines.
    always_comb begin
        pend  = pend_raw & mask;
        pend0 = pend & asgn;
        pend1 = pend & ~asgn;
        req0  = |pend0;
        req1  = |pend1;
        wake  = |(pend_raw & wake_en);
    end

    // Read mux; the write-only offsets read as zero.
    always_comb begin
        case (reg_addr)
            OFS_CFG0_SET: reg_rdata = cfg0;
            OFS_CFG1_SET: reg_rdata = cfg1;
            OFS_CFG2_SET: reg_rdata = cfg2;
            OFS_CFG2_CLR: reg_rdata = pend0;
            OFS_SSEL_SET: reg_rdata = ssel;
            OFS_SSEL_CLR: reg_rdata = pend1;
            OFS_ASGN_SET: reg_rdata = asgn;
            OFS_WAKE_SET: reg_rdata = wake_en;
            OFS_MASK_SET: reg_rdata = mask;
            OFS_RCAP:     reg_rdata = rcap;
            OFS_FCAP:     reg_rdata = fcap;
            OFS_TEST:     reg_rdata = test_bits;
            default:      reg_rdata = '0;
        endcase
    end

    // No request line can be active while every mask bit is clear.
    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!req0 && !req1));
    // Wake needs at least one wake-enabled source.
    assert_wake_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en == '0) |-> !wake);
    // The two lines never share a source, so both high means two pending bits.
    assert_two_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req0 && req1) |-> ($countones(pend_raw & mask) >= 2));
endmodule

// File: tb/irq_steer_ctrl_tb.sv
`timescale 1ns/100ps
module irq_steer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_in = '0;
    logic        req0, req1, wake;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_steer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .req0(req0), .req1(req1), .wake(wake)
    );

    // Vector: idx[14:10] mode[9:7] asgn[6] before[5] after[4] req0[3] req1[2] rcap[1] fcap[0]
    localparam logic [14:0] VEC [12] = '{
        {5'd3,  3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 rising captured
        {5'd7,  3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 falling ignored
        {5'd9,  3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 falling captured
        {5'd12, 3'b011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 rise in both mode
        {5'd15, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 fall in both mode
        {5'd20, 3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 level high active
        {5'd21, 3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 level high idle
        {5'd25, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 level low active
        {5'd30, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 level low idle
        {5'd31, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 disabled
        {5'd0,  3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 code 100
        {5'd5,  3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R9 code 111
    };

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'b001:  return "R4";
            3'b010:  return "R5";
            3'b011:  return "R6";
            3'b101:  return "R7";
            3'b110:  return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(8'h44, '1); wr(8'h4C, '1); wr(8'h54, '1);
        wr(8'h74, '1); wr(8'h64, '1); wr(8'h6C, '1);
        wr(8'h58, '1); wr(8'h80, '0);
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        wait_cyc(4);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h40, v); chk("R1 cfg0", v, '0);
        rd(8'h48, v); chk("R1 cfg1", v, '0);
        rd(8'h50, v); chk("R1 cfg2", v, '0);
        rd(8'h58, v); chk("R1 ssel", v, '1);
        rd(8'h60, v); chk("R1 asgn", v, '0);
        rd(8'h68, v); chk("R1 wake", v, '0);
        rd(8'h70, v); chk("R1 mask", v, '0);
        rd(8'h78, v); chk("R1 rcap", v, '0);
        rd(8'h7C, v); chk("R1 fcap", v, '0);
        rd(8'h80, v); chk("R1 test", v, '0);
        chk("R1 outputs", {29'd0, req0, req1, wake}, '0);

        // R2 set and clear act only on bits written as one
        wr(8'h70, 32'h0000_00F0); wr(8'h70, 32'h8000_0000);
        rd(8'h70, v); chk("R2 mask set", v, 32'h8000_00F0);
        wr(8'h74, 32'h0000_0030);
        rd(8'h70, v); chk("R2 mask clr", v, 32'h8000_00C0);
        wr(8'h60, 32'h0101_0000); wr(8'h64, 32'h0100_0000);
        rd(8'h60, v); chk("R2 asgn set clr", v, 32'h0001_0000);

        // R3 write at 0x54 clears cfg2; write at 0x5C clears source select
        wr(8'h50, 32'h0000_0041); wr(8'h54, 32'h0000_0040);
        rd(8'h50, v); chk("R3 cfg2 clr alias", v, 32'h0000_0001);
        wr(8'h5C, 32'h0000_0300);
        rd(8'h58, v); chk("R3 ssel clr alias", v, 32'hFFFF_FCFF);
        clear_all();

        // Table walk over trigger modes (R4 to R9)
        foreach (VEC[k]) begin
            logic [4:0] idx;
            logic [2:0] md;
            idx = VEC[k][14:10];
            md  = VEC[k][9:7];
            clear_all();
            @(negedge clk) src_in = 32'(VEC[k][5]) << idx;
            wait_cyc(4);
            wr(8'h78, '1); wr(8'h7C, '1);
            if (md[0]) wr(8'h40, 32'd1 << idx);
            if (md[1]) wr(8'h48, 32'd1 << idx);
            if (md[2]) wr(8'h50, 32'd1 << idx);
            if (VEC[k][6]) wr(8'h60, 32'd1 << idx);
            wr(8'h70, 32'd1 << idx);
            @(negedge clk) src_in = 32'(VEC[k][4]) << idx;
            wait_cyc(4);
            chk({mode_tag(md), " req0"}, {31'd0, req0}, {31'd0, VEC[k][3]});
            chk({mode_tag(md), " req1"}, {31'd0, req1}, {31'd0, VEC[k][2]});
            rd(8'h78, v); chk({mode_tag(md), " rcap"}, v, 32'(VEC[k][1]) << idx);
            rd(8'h7C, v); chk({mode_tag(md), " fcap"}, v, 32'(VEC[k][0]) << idx);
        end

        // R4 capture holds after input returns, cleared only by write
        clear_all();
        @(negedge clk) src_in = '0;
        wait_cyc(4);
        wr(8'h78, '1);
        wr(8'h40, 32'h4); wr(8'h60, 32'h4); wr(8'h70, 32'h4);
        @(negedge clk) src_in = 32'h4;
        wait_cyc(4);
        @(negedge clk) src_in = 32'h0;
        wait_cyc(4);
        chk("R4 hold req0", {31'd0, req0}, 32'd1);
        rd(8'h78, v); chk("R4 hold rcap", v, 32'h4);
        wr(8'h78, 32'h4);
        rd(8'h78, v); chk("R4 cleared rcap", v, 32'h0);
        chk("R4 cleared req0", {31'd0, req0}, 32'd0);

        // R10 and R3 pending bitmaps, steering and masking
        clear_all();
        wr(8'h40, 32'h0010_0100); wr(8'h50, 32'h0010_0100);
        wr(8'h60, 32'h0010_0000);
        wr(8'h70, 32'h0010_0100);
        @(negedge clk) src_in = 32'h0010_0100;
        wait_cyc(4);
        rd(8'h54, v); chk("R3 R10 pending line0", v, 32'h0010_0000);
        rd(8'h5C, v); chk("R3 R10 pending line1", v, 32'h0000_0100);
        chk("R10 both lines", {30'd0, req0, req1}, 32'd3);
        wr(8'h74, 32'h0010_0000);
        chk("R10 masked line0", {30'd0, req0, req1}, 32'd1);
        rd(8'h54, v); chk("R10 masked bitmap", v, 32'h0);

        // R11 wake ignores the mask
        wr(8'h74, '1);
        wr(8'h68, 32'h0010_0000);
        #1 chk("R11 wake on", {29'd0, req0, req1, wake}, 32'd1);
        wr(8'h6C, 32'h0010_0000);
        #1 chk("R11 wake off", {31'd0, wake}, 32'd0);

        // R12 test register as the source
        clear_all();
        @(negedge clk) src_in = '0;
        wait_cyc(4);
        wr(8'h40, 32'h10); wr(8'h50, 32'h10); wr(8'h60, 32'h10); wr(8'h70, 32'h10);
        wr(8'h5C, 32'h10);
        wr(8'h80, 32'h10);
        #1 chk("R12 test bit drives", {31'd0, req0}, 32'd1);
        wr(8'h80, 32'h0);
        @(negedge clk) src_in = 32'h10;
        wait_cyc(4);
        chk("R12 pin ignored", {31'd0, req0}, 32'd0);
        wr(8'h58, 32'h10);
        wait_cyc(2);
        chk("R12 pin selected", {31'd0, req0}, 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule